// File: doc/BRIEF.md
# DRAM Refresh Row Scheduler

This block keeps every row of a DRAM array refreshed within one retention window. It keeps a pointer to the next row that needs refresh and raises a request carrying that row address. It then holds the request until the command arbiter acknowledges it. Each acknowledge retires exactly one row and moves the pointer forward, wrapping to row zero after the last row. The block does not issue DRAM commands itself.

Time is divided into refresh intervals. The default interval is the retention window divided by the row count, measured by an internal clock divider derived from the clock frequency parameter. Alternatively, a timer elsewhere in the system can supply one pulse per interval. A retention period is `ROWS` consecutive intervals.

In spread mode, each interval owes one row. In burst mode, the close of a period owes a whole sweep of `ROWS` rows, which are requested back to back. Owed rows accumulate in a debt counter, so a slow arbiter never causes a refresh to be lost. The debt saturates at a limit, and a sticky overrun flag reports that the limit was reached. The mode input takes effect only at a period boundary.

The controller has two states. `ST_IDLE` means no rows are owed and the request is low. `ST_REQ` means at least one row is owed and the request is high. The transition `IDLE->REQ` fires when the next debt value becomes nonzero. The transition `REQ->IDLE` fires when the next debt value becomes zero. Otherwise each state holds.

Top module: `rfs_sched`

## Requirements
- R1: While reset is held and directly after it, `req_o` is 0, `row_o` is 0 and `overrun_o` is 0. The mode in force during the first period is spread.
- R2: With `ext_tick_sel_i`=0 and spread mode, an interval ends every `INTERVAL` = (`CLK_HZ`/1000*`RETAIN_MS`)/`ROWS` cycles. The first interval ends so that `req_o` is 1 after the `INTERVAL`-th rising edge following reset release, and 0 after the edge before it.
- R3: Once raised, `req_o` stays 1 and `row_o` stays unchanged on every cycle in which `ack_i` is 0.
- R4: A cycle with `req_o`=1 and `ack_i`=1 advances `row_o` by one at the next edge, from `ROWS`-1 to 0. `row_o` is always below `ROWS`.
- R5: `ack_i` asserted while `req_o` is 0 changes neither `row_o` nor `req_o`.
- R6: Intervals that end while a request is pending are accumulated. After n interval ends without acknowledge, exactly n acknowledges are needed before `req_o` falls.
- R7: In burst mode, no request is raised within a period. At the end of the period, `ROWS` rows are owed. With `ack_i` held at 1, `row_o` steps through `ROWS` consecutive rows on consecutive cycles, after which `req_o` falls.
- R8: `burst_mode_i` (1 = burst, 0 = spread) is captured only on the interval that ends a period. That interval is still accounted under the previous mode, and changes of the input inside a period have no effect.
- R9: When the debt reaches `PEND_MAX`, `overrun_o` becomes 1 and stays 1 until reset. The debt saturates at `PEND_MAX`, so after further intervals only `PEND_MAX` acknowledges are needed to clear the request.
- R10: With `ext_tick_sel_i`=1, each cycle with `ext_tick_i`=1 ends one interval and the internal divider has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| burst_mode_i | input | 1 | Requested mode: 1 burst, 0 spread; taken at period end |
| ext_tick_sel_i | input | 1 | 1 selects the external interval pulse instead of the divider |
| ext_tick_i | input | 1 | External interval pulse, one cycle per interval |
| ack_i | input | 1 | Arbiter acknowledge of the current row |
| req_o | output | 1 | Refresh request, held until acknowledged |
| row_o | output | $clog2(ROWS) | Row address to refresh |
| overrun_o | output | 1 | Sticky flag: debt reached `PEND_MAX` |

## Verification
The assertions take for granted that the arbiter obeys the handshake. An acknowledge only retires a row when it meets a raised request, and it is otherwise harmless. They also assume `ext_tick_i` is a single-cycle pulse, so that one pulse stands for one interval.

The stimulus drives every input on the falling edge. It pulses the external tick for exactly one cycle. It raises `ack_i` both alone, for single rows, and held across consecutive cycles, to drain accumulated and burst debt. It also raises `ack_i` deliberately while no request is pending, to show that case is ignored.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_REQ  = 1'b1
    } rfs_state_e;

    typedef enum logic {
        MODE_SPREAD = 1'b0,
        MODE_BURST  = 1'b1
    } rfs_mode_e;
endpackage

// File: rtl/rfs_tick_gen.sv
module rfs_tick_gen #(
    parameter int INTERVAL = 64,
    parameter int ROWS     = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ext_sel_i,
    input  logic ext_tick_i,
    output logic tick_o,
    output logic period_end_o
);
    localparam int DW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam int IW = (ROWS > 1) ? $clog2(ROWS) : 1;

    logic [DW-1:0] div_q;
    logic [IW-1:0] idx_q;
    logic          div_hit;

    assign div_hit = (div_q == DW'(INTERVAL - 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_q <= '0;
        end else if (div_hit) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick_o       = ext_sel_i ? ext_tick_i : div_hit;
    assign period_end_o = tick_o && (idx_q == IW'(ROWS - 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            idx_q <= '0;
        end else if (period_end_o) begin
            idx_q <= '0;
        end else if (tick_o) begin
            idx_q <= idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/rfs_debt.sv
module rfs_debt #(
    parameter int ROWS     = 8,
    parameter int PEND_MAX = 12,
    localparam int PW      = $clog2(PEND_MAX + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          add_one_i,
    input  logic          add_all_i,
    input  logic          take_i,
    output logic [PW-1:0] pend_d_o,
    output logic          overrun_o
);
    logic [PW-1:0] pend_q;
    logic [31:0]   sum;
    logic          hit_limit;

    always_comb begin
        sum = 32'(pend_q);
        if (add_one_i) sum = sum + 32'd1;
        if (add_all_i) sum = sum + 32'(ROWS);
        if (take_i)    sum = sum - 32'd1;
        hit_limit = (sum >= 32'(PEND_MAX));
        pend_d_o  = hit_limit ? PW'(PEND_MAX) : PW'(sum);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pend_q    <= '0;
            overrun_o <= 1'b0;
        end else begin
            pend_q <= pend_d_o;
            if (hit_limit) overrun_o <= 1'b1;
        end
    end
endmodule

// File: rtl/rfs_row_ctr.sv
module rfs_row_ctr #(
    parameter int ROWS = 8,
    localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          step_i,
    output logic [RW-1:0] row_o
);
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            row_o <= '0;
        end else if (step_i) begin
            row_o <= (row_o == RW'(ROWS - 1)) ? '0 : row_o + 1'b1;
        end
    end
endmodule

// File: rtl/rfs_sched.sv
module rfs_sched
    import rfs_pkg::*;
#(
    parameter int CLK_HZ    = 100_000_000,
    parameter int RETAIN_MS = 64,
    parameter int ROWS      = 8192,
    parameter int PEND_MAX  = 9216,
    localparam int RW       = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          burst_mode_i,
    input  logic          ext_tick_sel_i,
    input  logic          ext_tick_i,
    input  logic          ack_i,
    output logic          req_o,
    output logic [RW-1:0] row_o,
    output logic          overrun_o
);
    localparam longint PERIOD_CYC = longint'(CLK_HZ) / 1000 * longint'(RETAIN_MS);
    localparam int     INTERVAL   = int'(PERIOD_CYC / longint'(ROWS));
    localparam int     PW         = $clog2(PEND_MAX + 1);

    rfs_state_e    state_q, state_d;
    rfs_mode_e     mode_q;
    logic          tick, period_end, add_one, add_all, take;
    logic [PW-1:0] pend_d;

    rfs_tick_gen #(.INTERVAL(INTERVAL), .ROWS(ROWS)) u_tick (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .ext_sel_i    (ext_tick_sel_i),
        .ext_tick_i   (ext_tick_i),
        .tick_o       (tick),
        .period_end_o (period_end)
    );

    // Mode captured only at the interval that closes a period.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mode_q <= MODE_SPREAD;
        end else if (period_end) begin
            mode_q <= burst_mode_i ? MODE_BURST : MODE_SPREAD;
        end
    end

    assign add_one = tick && (mode_q == MODE_SPREAD);
    assign add_all = period_end && (mode_q == MODE_BURST);
    assign take    = req_o && ack_i;

    rfs_debt #(.ROWS(ROWS), .PEND_MAX(PEND_MAX)) u_debt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .add_one_i (add_one),
        .add_all_i (add_all),
        .take_i    (take),
        .pend_d_o  (pend_d),
        .overrun_o (overrun_o)
    );

    rfs_row_ctr #(.ROWS(ROWS)) u_row (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .step_i (take),
        .row_o  (row_o)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (pend_d != '0) state_d = ST_REQ;
            ST_REQ:  if (pend_d == '0) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        req_o = (state_q == ST_REQ);
    end
endmodule

// File: rtl/rfs_sched_chk.sv
module rfs_sched_chk #(
    parameter int ROWS = 8,
    localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          req_o,
    input logic          ack_i,
    input logic [RW-1:0] row_o,
    input logic          overrun_o
);
    assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o && !ack_i) |=> (req_o && $stable(row_o)));

    assert_row_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o && ack_i) |=>
            (row_o == (($past(row_o) == RW'(ROWS - 1)) ? '0 : $past(row_o) + 1'b1)));

    assert_row_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        32'(row_o) < 32'(ROWS));

    assert_idle_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_o |=> $stable(row_o));

    assert_overrun_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        overrun_o |=> overrun_o);
endmodule

bind rfs_sched rfs_sched_chk #(.ROWS(ROWS)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_o     (req_o),
    .ack_i     (ack_i),
    .row_o     (row_o),
    .overrun_o (overrun_o)
);

// File: tb/sim_rfs_sched.sv
module sim_rfs_sched;
    localparam int ROWS     = 8;
    localparam int PEND_MAX = 12;
    localparam int INTERVAL = 64; // 8000 Hz * 64 ms / 1000 / 8 rows

    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       burst_mode = 1'b0;
    logic       ext_sel = 1'b0;
    logic       ext_tick = 1'b0;
    logic       ack = 1'b0;
    logic       req;
    logic [2:0] row;
    logic       overrun;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    rfs_sched #(.CLK_HZ(8000), .RETAIN_MS(64), .ROWS(ROWS), .PEND_MAX(PEND_MAX)) u0 (
        .clk_i(clk), .rst_ni(rst_ni), .burst_mode_i(burst_mode),
        .ext_tick_sel_i(ext_sel), .ext_tick_i(ext_tick), .ack_i(ack),
        .req_o(req), .row_o(row), .overrun_o(overrun)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tick_pulse();
        ext_tick = 1'b1;
        step();
        ext_tick = 1'b0;
    endtask

    task automatic ack_pulse();
        ack = 1'b1;
        step();
        ack = 1'b0;
    endtask

    task automatic do_reset(input logic sel);
        @(negedge clk);
        rst_ni = 1'b0;
        burst_mode = 1'b0; ext_sel = sel; ext_tick = 1'b0; ack = 1'b0;
        repeat (3) step();
        chk("R1 req in reset", int'(req), 0);
        rst_ni = 1'b1;
        chk("R1 row after reset", int'(row), 0);
        chk("R1 overrun after reset", int'(overrun), 0);
    endtask

    task automatic t_divider_R2();
        do_reset(1'b0);
        repeat (INTERVAL - 1) step();
        chk("R2 req before first interval", int'(req), 0);
        step();
        chk("R2 req at first interval", int'(req), 1);
        ack_pulse();
        chk("R2 row after ack", int'(row), 1);
        chk("R2 req after ack", int'(req), 0);
        repeat (INTERVAL - 2) step();
        chk("R2 req before second interval", int'(req), 0);
        step();
        chk("R2 req at second interval", int'(req), 1);
    endtask

    task automatic t_hold_R3_idle_R5();
        do_reset(1'b1);
        ack_pulse();
        chk("R5 row after stray ack", int'(row), 0);
        chk("R5 req after stray ack", int'(req), 0);
        tick_pulse();
        for (int i = 0; i < 10; i++) begin
            step();
            chk("R3 req held", int'(req), 1);
            chk("R3 row held", int'(row), 0);
        end
        ack_pulse();
        chk("R3 row after ack", int'(row), 1);
        chk("R3 req after ack", int'(req), 0);
    endtask

    task automatic t_accum_R6();
        do_reset(1'b1);
        repeat (3) tick_pulse();
        for (int i = 1; i <= 3; i++) begin
            ack_pulse();
            chk("R6 row after ack", int'(row), i);
            chk("R6 req after ack", int'(req), (i < 3) ? 1 : 0);
        end
    endtask

    task automatic t_wrap_R4();
        do_reset(1'b1);
        for (int i = 1; i <= 9; i++) begin
            tick_pulse();
            ack_pulse();
            chk("R4 row step and wrap", int'(row), i % ROWS);
        end
    endtask

    task automatic t_burst_R7_R8();
        do_reset(1'b1);
        burst_mode = 1'b1;
        for (int i = 1; i <= ROWS; i++) begin
            tick_pulse();
            chk("R8 spread kept inside first period", int'(req), 1);
            ack_pulse();
        end
        chk("R8 row after first period", int'(row), 0);
        burst_mode = 1'b0;
        for (int i = 1; i < ROWS; i++) begin
            tick_pulse();
            chk("R7 no request inside burst period", int'(req), 0);
        end
        tick_pulse();
        chk("R7 request at period end", int'(req), 1);
        ack = 1'b1;
        for (int i = 1; i <= ROWS; i++) begin
            step();
            chk("R7 burst row sequence", int'(row), i % ROWS);
            chk("R7 burst req", int'(req), (i < ROWS) ? 1 : 0);
        end
        ack = 1'b0;
        tick_pulse();
        chk("R8 spread restored next period", int'(req), 1);
    endtask

    task automatic t_overrun_R9();
        do_reset(1'b1);
        repeat (PEND_MAX - 1) tick_pulse();
        chk("R9 overrun below limit", int'(overrun), 0);
        tick_pulse();
        chk("R9 overrun at limit", int'(overrun), 1);
        repeat (2) tick_pulse();
        ack = 1'b1;
        repeat (PEND_MAX - 1) step();
        chk("R9 req before saturated drain", int'(req), 1);
        step();
        ack = 1'b0;
        chk("R9 req after saturated drain", int'(req), 0);
        chk("R9 overrun sticky", int'(overrun), 1);
    endtask

    task automatic t_ext_R10();
        do_reset(1'b1);
        repeat (3 * INTERVAL) step();
        chk("R10 divider ignored", int'(req), 0);
        tick_pulse();
        chk("R10 external pulse", int'(req), 1);
    endtask

    initial begin
        t_divider_R2();
        t_hold_R3_idle_R5();
        t_accum_R6();
        t_wrap_R4();
        t_burst_R7_R8();
        t_overrun_R9();
        t_ext_R10();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule